// File: doc/BRIEF.md
# Fast Gate-A20 Controller

This block drives the gate-A20 output pin of a keyboard-controller-style slave host interface entirely in logic. It watches host write cycles on the slave port, recognises the gate-control command byte 0xD1, and on the next data write sets the gate to bit 1 of that data byte. Firmware and interrupts play no part, so the gate follows the host much sooner than a software-serviced path would.

The host-side signals (chip selects, write strobe, command/data address bit and data byte) are asynchronous to the block clock. They are brought in through a two-stage synchroniser. The write is acted on at the rising edge of the synchronised write strobe. A control-register enable bit selects between the fast gate state and an ordinary port data bit. A direction bit decides whether the pin is driven.

Top module: `fast_gate_ctrl`

## Requirements
- R1: After reset the fast gate state is 1 and no command is pending, so `gateOut` reads 1 while `fastEn` is 1.
- R2: A command write (`hostCmd`=1) of byte 0xD1 arms the block. The next data write (`hostCmd`=0) with data bit 1 equal to 1 drives `gateOut` to 1.
- R3: An armed data write with data bit 1 equal to 0 drives `gateOut` to 0.
- R4: A data write while not armed leaves `gateOut` unchanged. Any data write disarms the block, so a second data write after one 0xD1 has no effect.
- R5: A command write of any byte other than 0xD1 disarms the block.
- R6: Only writes with `hostCsN[GATE_CS]` low (index 0 by default) are decoded. Writes through any other chip select change neither the gate nor the pending command.
- R7: While `fastEn` is 0, `gateOut` equals `portData`, the pending command is held clear and the gate state does not change.
- R8: `gateOe` equals `pinDir`.
- R9: The gate changes at the third rising clock edge after the first edge that samples `hostWrN` high at the end of a write. It does not change while `hostWrN` is low.
- R10: Only data bit 1 matters: an armed write of 0xFD clears the gate and an armed write of 0x02 sets it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostCsN | input | CS_COUNT | Active-low host chip selects |
| hostWrN | input | 1 | Active-low host write strobe; the write is acted on at its rising edge |
| hostCmd | input | 1 | Host address bit: 1 for a command write, 0 for a data write |
| hostData | input | DATA_W | Host write data |
| fastEn | input | 1 | Fast gate enable from the host interface control register |
| pinDir | input | 1 | Pin direction bit: 1 for output |
| portData | input | 1 | Port data register bit used while the fast path is disabled |
| gateOut | output | 1 | Gate-A20 pin level |
| gateOe | output | 1 | Pin output enable |

## Verification
The gate is driven through complete command and data pairs with data bytes that differ only in bit 1. This shows that the decoder looks at that bit alone. Unarmed data writes, repeated data writes and foreign command bytes separate the arming rule from the data decoding. Writes on the other chip select, and writes made while disabled, test that non-matching traffic leaves the gate and the pending command alone. The end of one write is also watched clock by clock to pin down the three-edge latency.

// File: rtl/fgate_pkg.sv
package fgate_pkg;
  localparam logic [7:0] GATE_CMD = 8'hD1;
  localparam int         GATE_BIT = 1;

  typedef struct packed {
    logic setGate;
    logic clrGate;
  } gateStrobe_t;
endpackage

// File: rtl/fgate_sync.sv
module fgate_sync #(
  parameter int          WIDTH     = 8,
  parameter int          STAGES    = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);
  logic [WIDTH-1:0] stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[0] <= RESET_VAL;
          else       stage[0] <= dIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[s] <= RESET_VAL;
          else       stage[s] <= stage[s-1];
        end
      end
    end
  endgenerate

  assign dOut = stage[STAGES-1];
endmodule

// File: rtl/fgate_datapath.sv
module fgate_datapath
  import fgate_pkg::*;
#(
  parameter int CS_COUNT = 2,
  parameter int GATE_CS  = 0,
  parameter int DATA_W   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [CS_COUNT-1:0] hostCsN,
  input  logic                hostWrN,
  input  logic                hostCmd,
  input  logic [DATA_W-1:0]   hostData,
  input  logic                fastEn,
  input  logic                portData,
  input  gateStrobe_t         strobe,
  output logic                wrRise,
  output logic                csHit,
  output logic                isCmd,
  output logic [DATA_W-1:0]   dataByte,
  output logic                gateState,
  output logic                gateOut
);
  localparam int BUS_W = CS_COUNT + 2 + DATA_W;
  localparam logic [BUS_W-1:0] BUS_IDLE = {{CS_COUNT{1'b1}}, 1'b1, 1'b0, {DATA_W{1'b0}}};

  logic [BUS_W-1:0]    rawBus;
  logic [BUS_W-1:0]    syncBus;
  logic [CS_COUNT-1:0] syncCsN;
  logic                syncWrN;
  logic                wrPrev;

  assign rawBus = {hostCsN, hostWrN, hostCmd, hostData};

  fgate_sync #(
    .WIDTH(BUS_W), .STAGES(SYNC_STAGES), .RESET_VAL(BUS_IDLE)
  ) u_sync (
    .clk(clk), .rstN(rstN), .dIn(rawBus), .dOut(syncBus)
  );

  assign {syncCsN, syncWrN, isCmd, dataByte} = syncBus;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wrPrev <= 1'b1;
    else       wrPrev <= syncWrN;
  end

  assign wrRise = syncWrN & ~wrPrev;
  assign csHit  = ~syncCsN[GATE_CS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               gateState <= 1'b1;
    else if (strobe.setGate) gateState <= 1'b1;
    else if (strobe.clrGate) gateState <= 1'b0;
  end

  assign gateOut = fastEn ? gateState : portData;
endmodule

// File: rtl/fgate_ctrl.sv
module fgate_ctrl
  import fgate_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fastEn,
  input  logic              wrRise,
  input  logic              csHit,
  input  logic              isCmd,
  input  logic [DATA_W-1:0] dataByte,
  output gateStrobe_t       strobe,
  output logic              armed
);
  logic hostHit;
  logic cmdHit;
  logic dataHit;

  assign hostHit = fastEn & wrRise & csHit;
  assign cmdHit  = hostHit & isCmd;
  assign dataHit = hostHit & ~isCmd;

  always_comb begin
    strobe.setGate = dataHit & armed & dataByte[GATE_BIT];
    strobe.clrGate = dataHit & armed & ~dataByte[GATE_BIT];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        armed <= 1'b0;
    else if (!fastEn) armed <= 1'b0;
    else if (cmdHit)  armed <= (dataByte[7:0] == GATE_CMD);
    else if (dataHit) armed <= 1'b0;
  end
endmodule

// File: rtl/fast_gate_ctrl.sv
module fast_gate_ctrl
  import fgate_pkg::*;
#(
  parameter int CS_COUNT    = 2,
  parameter int GATE_CS     = 0,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [CS_COUNT-1:0] hostCsN,
  input  logic                hostWrN,
  input  logic                hostCmd,
  input  logic [DATA_W-1:0]   hostData,
  input  logic                fastEn,
  input  logic                pinDir,
  input  logic                portData,
  output logic                gateOut,
  output logic                gateOe
);
  gateStrobe_t       strobe;
  logic              wrRise;
  logic              csHit;
  logic              isCmd;
  logic [DATA_W-1:0] dataByte;
  logic              gateState;
  logic              armed;

  fgate_datapath #(
    .CS_COUNT(CS_COUNT), .GATE_CS(GATE_CS), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .hostCsN(hostCsN), .hostWrN(hostWrN),
    .hostCmd(hostCmd), .hostData(hostData), .fastEn(fastEn),
    .portData(portData), .strobe(strobe), .wrRise(wrRise), .csHit(csHit),
    .isCmd(isCmd), .dataByte(dataByte), .gateState(gateState), .gateOut(gateOut)
  );

  fgate_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .fastEn(fastEn), .wrRise(wrRise), .csHit(csHit),
    .isCmd(isCmd), .dataByte(dataByte), .strobe(strobe), .armed(armed)
  );

  assign gateOe = pinDir;
endmodule

// File: rtl/fgate_checker.sv
module fgate_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              fastEn,
  input logic              wrRise,
  input logic              csHit,
  input logic              isCmd,
  input logic [DATA_W-1:0] dataByte,
  input logic              gateState,
  input logic              armed
);
  logic cmdHit;
  logic dataHit;
  assign cmdHit  = fastEn && wrRise && csHit && isCmd;
  assign dataHit = fastEn && wrRise && csHit && !isCmd;

  assert_reset_state_R1: assert property (@(posedge clk)
    !rstN |=> (gateState && !armed));

  assert_arm_on_cmd_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cmdHit && dataByte[7:0] == 8'hD1) |=> armed);

  assert_set_on_data_R2: assert property (@(posedge clk) disable iff (!rstN)
    (dataHit && armed && dataByte[1]) |=> gateState);

  assert_clr_on_data_R3: assert property (@(posedge clk) disable iff (!rstN)
    (dataHit && armed && !dataByte[1]) |=> !gateState);

  assert_unarmed_data_R4: assert property (@(posedge clk) disable iff (!rstN)
    (dataHit && !armed) |=> $stable(gateState));

  assert_data_disarms_R4: assert property (@(posedge clk) disable iff (!rstN)
    dataHit |=> !armed);

  assert_other_cmd_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cmdHit && dataByte[7:0] != 8'hD1) |=> !armed);

  assert_foreign_cs_R6: assert property (@(posedge clk) disable iff (!rstN)
    (fastEn && !(wrRise && csHit)) |=> ($stable(armed) && $stable(gateState)));

  assert_disabled_R7: assert property (@(posedge clk) disable iff (!rstN)
    !fastEn |=> (!armed && $stable(gateState)));

  assert_change_needs_edge_R9: assert property (@(posedge clk) disable iff (!rstN)
    (gateState != $past(gateState)) |-> $past(wrRise));
endmodule

bind fast_gate_ctrl fgate_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .fastEn(fastEn), .wrRise(wrRise), .csHit(csHit),
  .isCmd(isCmd), .dataByte(dataByte), .gateState(gateState), .armed(armed)
);

// File: tb/tb_fast_gate_ctrl.sv
module tb_fast_gate_ctrl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] hostCsN = 2'b11;
  logic       hostWrN = 1'b1;
  logic       hostCmd = 1'b0;
  logic [7:0] hostData = 8'h00;
  logic       fastEn = 1'b1;
  logic       pinDir = 1'b1;
  logic       portData = 1'b0;
  logic       gateOut;
  logic       gateOe;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fast_gate_ctrl dut (
    .clk(clk), .rstN(rstN), .hostCsN(hostCsN), .hostWrN(hostWrN),
    .hostCmd(hostCmd), .hostData(hostData), .fastEn(fastEn),
    .pinDir(pinDir), .portData(portData), .gateOut(gateOut), .gateOe(gateOe)
  );

  // Behavioural reference: history of raw host samples {cmd, hit, wr, data}
  logic [10:0] hist[$];
  logic        mGate;
  logic        mArmed;
  localparam logic [10:0] IDLE = {1'b0, 1'b0, 1'b1, 8'h00};

  always @(posedge clk) begin
    logic [10:0] cur, d2, d3;
    cur = {hostCmd, ~hostCsN[0], hostWrN, hostData};
    if (!rstN) begin
      hist = '{IDLE, IDLE, IDLE};
      mGate = 1'b1;
      mArmed = 1'b0;
    end else begin
      d3 = hist[0];
      d2 = hist[1];
      if (!fastEn) mArmed = 1'b0;
      else if (d2[8] && !d3[8] && d2[9]) begin
        if (d2[10]) mArmed = (d2[7:0] == 8'hD1);
        else begin
          if (mArmed) mGate = d2[1];
          mArmed = 1'b0;
        end
      end
      void'(hist.pop_front());
      hist.push_back(cur);
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      checks++;
      if (gateOut !== (fastEn ? mGate : portData)) begin
        errors++;
        $display("FAIL R2/R3 model compare: gateOut=%b expected=%b at %0t",
                 gateOut, fastEn ? mGate : portData, $time);
      end
      checks++;
      if (gateOe !== pinDir) begin
        errors++;
        $display("FAIL R8 model compare: gateOe=%b expected=%b", gateOe, pinDir);
      end
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic hostWrite(input int cs, input bit cmd, input logic [7:0] d);
    @(negedge clk);
    hostCsN = 2'b11;
    hostCsN[cs] = 1'b0;
    hostCmd = cmd;
    hostData = d;
    hostWrN = 1'b0;
    repeat (3) @(negedge clk);
    hostWrN = 1'b1;
    repeat (4) @(negedge clk);
    hostCsN = 2'b11;
    repeat (2) @(negedge clk);
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      finishRun();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset gate", gateOut, 1'b1);
    check("R8 oe after reset", gateOe, 1'b1);

    // R9 latency with an armed clear (also R3)
    hostWrite(0, 1'b1, 8'hD1);
    @(negedge clk);
    hostCsN = 2'b10; hostCmd = 1'b0; hostData = 8'h00; hostWrN = 1'b0;
    repeat (4) @(negedge clk);
    check("R9 no change while strobe low", gateOut, 1'b1);
    hostWrN = 1'b1;
    @(negedge clk);
    check("R9 edge+1 unchanged", gateOut, 1'b1);
    @(negedge clk);
    check("R9 edge+2 unchanged", gateOut, 1'b1);
    @(negedge clk);
    check("R9 edge+3 updated / R3 cleared", gateOut, 1'b0);
    repeat (2) @(negedge clk);
    hostCsN = 2'b11;
    repeat (2) @(negedge clk);

    hostWrite(0, 1'b1, 8'hD1); hostWrite(0, 1'b0, 8'h02);
    check("R2 set by bit1", gateOut, 1'b1);
    hostWrite(0, 1'b1, 8'hD1); hostWrite(0, 1'b0, 8'hFD);
    check("R10 0xFD clears", gateOut, 1'b0);
    hostWrite(0, 1'b1, 8'hD1); hostWrite(0, 1'b0, 8'h02);
    check("R10 0x02 sets", gateOut, 1'b1);

    hostWrite(0, 1'b0, 8'h00);
    check("R4 unarmed data ignored", gateOut, 1'b1);
    hostWrite(0, 1'b1, 8'hD1); hostWrite(0, 1'b0, 8'h02); hostWrite(0, 1'b0, 8'h00);
    check("R4 second data ignored", gateOut, 1'b1);

    hostWrite(0, 1'b1, 8'hD1); hostWrite(0, 1'b1, 8'h60); hostWrite(0, 1'b0, 8'h00);
    check("R5 other command disarms", gateOut, 1'b1);

    hostWrite(1, 1'b1, 8'hD1); hostWrite(1, 1'b0, 8'h00);
    check("R6 foreign cs pair ignored", gateOut, 1'b1);
    hostWrite(0, 1'b1, 8'hD1); hostWrite(1, 1'b0, 8'h00);
    check("R6 foreign cs data ignored", gateOut, 1'b1);
    hostWrite(0, 1'b0, 8'h00);
    check("R6 armed state kept", gateOut, 1'b0);

    fastEn = 1'b0; portData = 1'b1;
    @(negedge clk);
    check("R7 follows port data 1", gateOut, 1'b1);
    portData = 1'b0;
    @(negedge clk);
    check("R7 follows port data 0", gateOut, 1'b0);
    hostWrite(0, 1'b1, 8'hD1); hostWrite(0, 1'b0, 8'h02);
    fastEn = 1'b1;
    @(negedge clk);
    check("R7 gate held while disabled", gateOut, 1'b0);
    fastEn = 1'b0;
    hostWrite(0, 1'b1, 8'hD1);
    fastEn = 1'b1;
    hostWrite(0, 1'b0, 8'h02);
    check("R7 arming cleared while disabled", gateOut, 1'b0);

    pinDir = 1'b0;
    @(negedge clk);
    check("R8 oe off", gateOe, 1'b0);
    pinDir = 1'b1;
    @(negedge clk);
    check("R8 oe on", gateOe, 1'b1);

    finishRun();
  end
endmodule